// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a processor load/store port and a plain lower-level memory port. It holds recently used blocks in a two-way set-associative array. Each address is split into a tag, a set index and a word offset. The index selects one set of two ways, and both stored tags are compared in the same cycle. A request to a block that is already in the cache completes in the cycle it is presented, with no memory traffic. Stores are kept in the cache, and the block is marked dirty.

On a miss the controller chooses a victim way. An empty way is taken first. When both ways hold data, the way that was used less recently is taken. If the victim is dirty, it is first written to memory one word per beat. The missing block is then read one word per beat. After that the controller returns to idle, and the held request completes as a hit. The processor keeps `cpu_req` and its address and data stable until it sees `cpu_done`. Stores write one full word.

Top module: `wb_cache2w`

## Requirements
- R1: Both ways of the indexed set are compared in the same cycle. A request that matches a valid way raises `cpu_done` in the cycle it is presented, with no memory beat. At most one way matches.
- R2: Address bits [3:2] select the word, bits [7:4] select the set and bits [31:8] form the tag. A load returns the addressed word of the matching way.
- R3: Every hit marks the accessed way as the most recently used way of its set.
- R4: When a set receives a block and one of its ways is invalid, the invalid way is filled, and no valid block is evicted.
- R5: When both ways of the set are valid, the way not used most recently is evicted.
- R6: A store hit updates only the cache word and marks the block dirty. No memory write takes place.
- R7: A dirty victim is written back as 4 write beats, to ascending word addresses of the victim's own block, carrying its current contents.
- R8: A clean victim is discarded without any memory write beat.
- R9: The memory port works as follows:
  - A beat completes when `mem_valid` and `mem_ready` are both high. Read data is taken in that same cycle.
  - A miss issues the write-back beats first (only for a dirty victim). It then issues 4 read beats to ascending addresses of the missing block, starting at word 0, and then completes the request.
  - While `mem_ready` is low, the address, direction and write data are held.
- R10: Reset clears every valid, dirty and recency bit. After reset every access misses, and no write-back occurs for blocks that were dirty before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | Request completes this cycle |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read beat |

## Verification
The hardest situation to reach from the ports is the eviction of a dirty block chosen by recency rather than by vacancy. The set must first be filled in a known order, one way must be made dirty, and the other way must then be touched last, all before a third tag for the same set arrives. Directed sequences build exactly this history on chosen sets. A second sequence repeats the dirty-eviction setup across a reset to show that no write-back survives it. The memory model withholds `mem_ready` every third cycle, so every write-back and refill also passes through stalls.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  localparam int unsigned WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
`timescale 1ns/1ps
// Tag, valid, dirty and recency state with a parallel two-way compare.
module wbc_tag_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 24,
  parameter int unsigned IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      lk_idx,
  input  logic [TAG_W-1:0]      lk_tag,
  output logic [1:0]            hit_o,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic                  mru_o,
  input  logic                  touch_en,
  input  logic [IDX_W-1:0]      touch_idx,
  input  logic                  touch_way,
  input  logic                  touch_dirty,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic                  fill_way,
  input  logic [TAG_W-1:0]      fill_tag
);
  logic [1:0]            valid_q [SETS];
  logic [1:0]            dirty_q [SETS];
  logic [SETS-1:0]       mru_q;
  logic [1:0][TAG_W-1:0] tag_q   [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      mru_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx][fill_way] <= 1'b1;
        dirty_q[fill_idx][fill_way] <= 1'b0;
      end
      if (touch_en) begin
        mru_q[touch_idx] <= touch_way;
        if (touch_dirty) begin
          dirty_q[touch_idx][touch_way] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx][fill_way] <= fill_tag;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign valid_o[w] = valid_q[lk_idx][w];
    assign dirty_o[w] = dirty_q[lk_idx][w];
    assign tag_o[w]   = tag_q[lk_idx][w];
    assign hit_o[w]   = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign mru_o = mru_q[lk_idx];
endmodule

// File: rtl/wbc_data_store.sv
`timescale 1ns/1ps
// Block data for both ways, one word read per way, one word write port.
module wbc_data_store #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned WRD_W  = 2
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [WRD_W-1:0]       rd_wrd,
  output logic [1:0][DATA_W-1:0] rd_o,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_way,
  input  logic [WRD_W-1:0]       wr_wrd,
  input  logic [DATA_W-1:0]      wr_data
);
  logic [DATA_W-1:0] store_q [SETS][2][WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx][wr_way][wr_wrd] <= wr_data;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_o[w] = store_q[rd_idx][w][rd_wrd];
  end
endmodule

// File: rtl/wbc_victim.sv
`timescale 1ns/1ps
// Replacement choice: an empty way first, otherwise the less recent way.
module wbc_victim (
  input  logic [1:0] valid_i,
  input  logic       mru_i,
  output logic       way_o
);
  always_comb begin
    if (!valid_i[0]) begin
      way_o = 1'b0;
    end else if (!valid_i[1]) begin
      way_o = 1'b1;
    end else begin
      way_o = ~mru_i;
    end
  end
endmodule

// File: rtl/wb_cache2w.sv
`timescale 1ns/1ps
module wb_cache2w #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wbc_pkg::*;

  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned WRD_W = $clog2(WORDS);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - WRD_W - OFF_W;
  localparam int unsigned LAST  = WORDS - 1;

  // Address fields of the request
  logic [TAG_W-1:0] c_tag;
  logic [IDX_W-1:0] c_idx;
  logic [WRD_W-1:0] c_wrd;
  assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign c_idx = cpu_addr[OFF_W+WRD_W +: IDX_W];
  assign c_wrd = cpu_addr[OFF_W +: WRD_W];

  // Control state
  wbc_state_e       state, state_nx;
  logic [WRD_W-1:0] cnt;
  logic [TAG_W-1:0] m_tag;
  logic [IDX_W-1:0] m_idx;
  logic             vic_way_q;
  logic [TAG_W-1:0] vic_tag_q;

  // Lookup results
  logic [IDX_W-1:0]      lk_idx;
  logic [WRD_W-1:0]      rd_wrd;
  logic [1:0]            hit_w;
  logic [1:0]            way_valid;
  logic [1:0]            way_dirty;
  logic [1:0][TAG_W-1:0] way_tag;
  logic                  set_mru;
  logic                  vic_sel;
  logic [1:0][DATA_W-1:0] rd_word;

  logic hit_any, hit_way, miss_start, vic_dirty, beat, last_beat;
  logic dat_we, dat_way;
  logic [IDX_W-1:0]  dat_idx;
  logic [WRD_W-1:0]  dat_wrd;
  logic [DATA_W-1:0] dat_wdata;
  logic fill_en;

  assign lk_idx  = (state == ST_IDLE) ? c_idx : m_idx;
  assign rd_wrd  = (state == ST_IDLE) ? c_wrd : cnt;
  assign hit_any = |hit_w;
  assign hit_way = hit_w[1];

  wbc_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_idx      (lk_idx),
    .lk_tag      (c_tag),
    .hit_o       (hit_w),
    .valid_o     (way_valid),
    .dirty_o     (way_dirty),
    .tag_o       (way_tag),
    .mru_o       (set_mru),
    .touch_en    (cpu_done),
    .touch_idx   (c_idx),
    .touch_way   (hit_way),
    .touch_dirty (cpu_we),
    .fill_en     (fill_en),
    .fill_idx    (m_idx),
    .fill_way    (vic_way_q),
    .fill_tag    (m_tag)
  );

  wbc_victim u_vic (
    .valid_i (way_valid),
    .mru_i   (set_mru),
    .way_o   (vic_sel)
  );

  wbc_data_store #(
    .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .WRD_W(WRD_W)
  ) u_data (
    .clk     (clk),
    .rd_idx  (lk_idx),
    .rd_wrd  (rd_wrd),
    .rd_o    (rd_word),
    .wr_en   (dat_we),
    .wr_idx  (dat_idx),
    .wr_way  (dat_way),
    .wr_wrd  (dat_wrd),
    .wr_data (dat_wdata)
  );

  // Processor side
  assign cpu_done   = (state == ST_IDLE) && cpu_req && hit_any;
  assign cpu_rdata  = rd_word[hit_way];
  assign miss_start = (state == ST_IDLE) && cpu_req && !hit_any;
  assign vic_dirty  = way_valid[vic_sel] && way_dirty[vic_sel];

  // Memory side
  assign mem_valid = (state != ST_IDLE);
  assign mem_write = (state == ST_WBACK);
  assign mem_addr  = {(state == ST_WBACK) ? vic_tag_q : m_tag, m_idx, cnt, {OFF_W{1'b0}}};
  assign mem_wdata = rd_word[vic_way_q];
  assign beat      = mem_valid && mem_ready;
  assign last_beat = (cnt == WRD_W'(LAST));
  assign fill_en   = (state == ST_REFILL) && beat && last_beat;

  // Data write port: store hit or refill beat
  always_comb begin
    dat_we    = 1'b0;
    dat_idx   = c_idx;
    dat_way   = hit_way;
    dat_wrd   = c_wrd;
    dat_wdata = cpu_wdata;
    if (cpu_done && cpu_we) begin
      dat_we = 1'b1;
    end else if ((state == ST_REFILL) && beat) begin
      dat_we    = 1'b1;
      dat_idx   = m_idx;
      dat_way   = vic_way_q;
      dat_wrd   = cnt;
      dat_wdata = mem_rdata;
    end
  end

  // Next state
  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (miss_start) state_nx = vic_dirty ? ST_WBACK : ST_REFILL;
      ST_WBACK:  if (beat && last_beat) state_nx = ST_REFILL;
      ST_REFILL: if (beat && last_beat) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      m_tag     <= '0;
      m_idx     <= '0;
      vic_way_q <= 1'b0;
      vic_tag_q <= '0;
    end else begin
      state <= state_nx;
      if (beat) begin
        cnt <= cnt + WRD_W'(1);
      end
      if (miss_start) begin
        m_tag     <= c_tag;
        m_idx     <= c_idx;
        vic_way_q <= vic_sel;
        vic_tag_q <= way_tag[vic_sel];
      end
    end
  end
endmodule

// File: rtl/wb_cache2w_chk.sv
`timescale 1ns/1ps
module wb_cache2w_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [1:0]        hit_vec
);
  // R1
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1
  done_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (cpu_req && !mem_valid));

  // R6
  after_done_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !mem_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R7
  stall_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_ready) |=> $stable(mem_wdata));

  // R9
  wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write) |=> !(mem_valid && mem_write));
endmodule

bind wb_cache2w wb_cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_done  (cpu_done),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .hit_vec   (hit_w)
);

// File: tb/wb_cache2w_bench.sv
`timescale 1ns/1ps
module wb_cache2w_bench;
  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_done;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  wb_cache2w u_wb_cache2w (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory model and reference contents
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];
  int          wr_beats, rd_beats, tick;
  bit          bad_order;
  logic [31:0] wb_addr [4];
  logic [31:0] rf_addr [4];

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A00_00A5;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : dflt(a);
  endfunction

  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : dflt(a);
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {t[23:0], s[3:0], w[1:0], 2'b00};
  endfunction

  always @(negedge clk) begin
    tick++;
    mem_ready = ((tick % 3) != 1);
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        mem_m[mem_addr] = mem_wdata;
        if (rd_beats > 0) bad_order = 1'b1;
        if (wr_beats < 4) wb_addr[wr_beats] = mem_addr;
        wr_beats++;
      end else begin
        mem_rdata = mem_rd(mem_addr);
        if (rd_beats < 4) rf_addr[rd_beats] = mem_addr;
        rd_beats++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    wr_beats = 0; rd_beats = 0; bad_order = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    #1;
    while (!cpu_done && cyc < 2000) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    if (we) ref_m[a] = wd;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Read expecting a hit with the reference value
  task automatic rd_hit(input logic [31:0] a, input string rq);
    logic [31:0] v; int c;
    access(1'b0, a, '0, v, c);
    chk(c == 0, rq, c, 0);
    chk(wr_beats + rd_beats == 0, rq, wr_beats + rd_beats, 0);
    chk(v == ref_rd(a), rq, v, ref_rd(a));
  endtask

  // Read expecting a miss with a given write-back beat count
  task automatic rd_miss(input logic [31:0] a, input int exp_wr, input string rq);
    logic [31:0] v; int c;
    access(1'b0, a, '0, v, c);
    chk(c > 0, rq, c, 1);
    chk(wr_beats == exp_wr, rq, wr_beats, exp_wr);
    chk(rd_beats == 4, rq, rd_beats, 4);
    chk(v == ref_rd(a), rq, v, ref_rd(a));
  endtask

  task automatic t_reset_state();
    #1;
    chk(cpu_done == 1'b0, "R10 reset done", cpu_done, 0);
    chk(mem_valid == 1'b0, "R10 reset mem_valid", mem_valid, 0);
  endtask

  task automatic t_cold_fill();
    rd_miss(mk(1, 3, 0), 0, "R9 cold miss");
    chk(rf_addr[0] == mk(1, 3, 0), "R9 first read addr", rf_addr[0], mk(1, 3, 0));
    chk(rf_addr[3] == mk(1, 3, 3), "R9 last read addr", rf_addr[3], mk(1, 3, 3));
  endtask

  task automatic t_word_select();
    for (int w = 0; w < 4; w++) rd_hit(mk(1, 3, w), "R2 word mux");
    rd_hit(mk(1, 3, 2), "R1 repeat hit");
  endtask

  task automatic t_two_ways();
    rd_miss(mk(2, 3, 1), 0, "R4 second way");
    rd_hit(mk(1, 3, 1), "R4 first way kept");
    rd_hit(mk(2, 3, 3), "R2 other way word");
  endtask

  task automatic t_recency();
    rd_hit(mk(1, 3, 0), "R3 touch old way");
    rd_miss(mk(3, 3, 0), 0, "R3 third tag");
    rd_hit(mk(1, 3, 2), "R3 touched way kept");
    rd_miss(mk(2, 3, 0), 0, "R3 untouched way evicted");
  endtask

  task automatic t_lru();
    rd_miss(mk(4, 5, 0), 0, "R5 fill a");
    rd_miss(mk(5, 5, 0), 0, "R5 fill b");
    rd_miss(mk(6, 5, 0), 0, "R5 evict oldest");
    rd_hit(mk(5, 5, 1), "R5 newer kept");
    rd_miss(mk(4, 5, 0), 0, "R5 oldest gone");
  endtask

  task automatic t_dirty();
    logic [31:0] v; int c;
    access(1'b1, mk(7, 7, 2), 32'hDEAD_BEEF, v, c);
    chk(c > 0 && wr_beats == 0, "R6 store miss fill", wr_beats, 0);
    access(1'b1, mk(7, 7, 2), 32'hCAFE_0123, v, c);
    chk(c == 0, "R6 store hit latency", c, 0);
    chk(wr_beats + rd_beats == 0, "R6 store hit no beat", wr_beats + rd_beats, 0);
    chk(mem_rd(mk(7, 7, 2)) == dflt(mk(7, 7, 2)), "R6 memory untouched",
        mem_rd(mk(7, 7, 2)), dflt(mk(7, 7, 2)));
    rd_hit(mk(7, 7, 2), "R6 store visible");
    rd_miss(mk(8, 7, 0), 0, "R4 fill empty way");
    rd_miss(mk(9, 7, 0), 4, "R7 dirty eviction");
    chk(!bad_order, "R9 writes before reads", bad_order, 0);
    chk(wb_addr[0] == mk(7, 7, 0), "R7 wb first addr", wb_addr[0], mk(7, 7, 0));
    chk(wb_addr[3] == mk(7, 7, 3), "R7 wb last addr", wb_addr[3], mk(7, 7, 3));
    chk(mem_rd(mk(7, 7, 2)) == 32'hCAFE_0123, "R7 wb data",
        mem_rd(mk(7, 7, 2)), 32'hCAFE_0123);
    rd_miss(mk(7, 7, 2), 0, "R8 clean victim dropped");
  endtask

  task automatic t_reset_clears();
    logic [31:0] v; int c;
    rd_miss(mk(10, 9, 0), 0, "R4 fill set 9");
    access(1'b1, mk(10, 9, 1), 32'h1357_9BDF, v, c);
    chk(c == 0, "R6 store hit set 9", c, 0);
    do_reset();
    ref_m = mem_m;
    rd_miss(mk(10, 9, 1), 0, "R10 valid cleared");
    rd_miss(mk(11, 9, 0), 0, "R10 fill other way");
    rd_miss(mk(12, 9, 0), 0, "R10 dirty cleared");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b0; mem_rdata = '0;
    tick = 0; wr_beats = 0; rd_beats = 0; bad_order = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_cold_fill();
    t_word_select();
    t_two_ways();
    t_recency();
    t_lru();
    t_dirty();
    t_reset_clears();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule